// File: doc/BRIEF.md
# Collision-Vector Task Admission Controller

This block decides, one clock at a time, whether a new task may be launched into a non-linear pipeline whose stage usage is fixed. The set of latencies that would make two tasks collide in some stage is given as a parameter mask. The block holds a collision-vector state that is derived from that mask. A request is granted only in a cycle in which the state says that the elapsed distance since earlier launches is safe. On every grant the block folds the initial collision vector back into the state, so the spacing it allows follows the state diagram of the pipeline.

The state vector is visible at the ports. The block also reports how many cycles have passed since the previous grant and how many cycles remain until the next permitted launch. When a request is held high, the block grants at the earliest permitted cycle, which is the greedy schedule. An optional greedy mode input goes further. In that mode a request that arrives in a blocked cycle is remembered and granted as soon as the state allows. Without the mode, a blocked request is dropped.

Top module: `init_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the state vector, the latency counter and any remembered request are cleared, and `grant_o` is low during every cycle in which `rst` is high.
- R2: Bit i-1 of `cv_o` stands for latency i. A grant from the empty state loads `FORBID_MASK` into the state, which is 5'b10010 by default (latencies 2 and 5 forbidden).
- R3: `grant_o` is high in a cycle exactly when a request is effective in that cycle and bit 0 of `cv_o` is 0.
- R4: Each clock the state shifts right by one place with a zero entering at the top. In a cycle with a grant, the shifted value is also ORed with `FORBID_MASK`.
- R5: With the default mask, a request made exactly 2 or exactly 5 cycles after a lone grant is refused. A request made 1, 3, 4 or 6 cycles after it is accepted.
- R6: Once the state is all zeros, it stays all zeros until a grant, and any request in that state is granted.
- R7: With a request held high from the empty state and the default mask, grants fall at cycle offsets 0, 1, 4, 7, 8, 11, 14. The state seen after the grants cycles through 10010, 11011, 10011.
- R8: `lat_o` gives the number of cycles since the previous grant. It is 0 when there has been no grant since reset, and it saturates at N+1.
- R9: `wait_o` gives the number of cycles from the current one until the first permitted cycle. That is the index of the lowest zero bit of `cv_o`, or N when every bit is set.
- R10: While `greedy_i` is high, a refused request is remembered and granted in the first permitted cycle, even if `req_i` is low by then. While `greedy_i` is low, a refused request is dropped, and dropping `greedy_i` discards any remembered request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Task launch request for the current cycle |
| greedy_i | input | 1 | Keep refused requests pending until permitted |
| grant_o | output | 1 | Task may enter the pipeline in this cycle |
| lat_o | output | $clog2(N+2) | Cycles since previous grant, valid with grant_o |
| cv_o | output | N | Current collision-vector state, bit 0 = latency 1 |
| wait_o | output | $clog2(N+1) | Cycles until the next permitted launch |

## Verification
A corrupted state bit shows up first at `cv_o` on the very next cycle. It reaches `grant_o` only when that bit shifts down to position 0, which is at most N cycles later. The checks therefore compare `cv_o` at fixed offsets after a grant as well as the grant pattern itself. A wrong OR or a wrong shift changes the latency sequence under a held request, so the 1, 3, 3 rhythm and the refusals at offsets 2 and 5 expose it within one period of the cycle. Counter and pending-request faults are caught through `lat_o` and through the grant that should, or should not, follow a refused request.

// File: rtl/init_ctrl_pkg.sv
package init_ctrl_pkg;

   // width of the latency counter: must hold 0..N+1
   function automatic int lat_width(input int n);
      return $clog2(n + 2);
   endfunction

   // width of the wait report: must hold 0..N
   function automatic int wait_width(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/ic_state.sv
module ic_state #(
   parameter int            N   = 5,
   parameter logic [N-1:0]  ICV = 5'b10010
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         grant_i,
   output logic [N-1:0] cv_o
);

   logic [N-1:0] cv_q;
   logic [N-1:0] fold;

   assign fold = grant_i ? ICV : '0;

   always_ff @(posedge clk) begin
      if (rst) cv_q <= '0;
      else     cv_q <= (cv_q >> 1) | fold;
   end

   assign cv_o = cv_q;

   // R3
   grant_safe_chk: assert property (@(posedge clk) disable iff (rst)
      grant_i |-> !cv_q[0]);

   // R4
   fold_in_chk: assert property (@(posedge clk) disable iff (rst)
      grant_i |=> ((cv_q & ICV) == ICV));

   // R4
   shift_only_chk: assert property (@(posedge clk) disable iff (rst)
      !grant_i |=> (cv_q == ($past(cv_q) >> 1)));

endmodule

// File: rtl/ic_latcnt.sv
module ic_latcnt #(
   parameter int N  = 5,
   parameter int LW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          grant_i,
   output logic [LW-1:0] lat_o
);

   localparam logic [LW-1:0] SAT = LW'(N + 1);

   logic [LW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                              cnt_q <= '0;
      else if (grant_i)                     cnt_q <= LW'(1);
      else if (cnt_q != '0 && cnt_q != SAT) cnt_q <= cnt_q + LW'(1);
   end

   assign lat_o = cnt_q;

   // R8
   restart_chk: assert property (@(posedge clk) disable iff (rst)
      grant_i |=> (cnt_q == LW'(1)));

   // R8
   sat_bound_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= SAT);

endmodule

// File: rtl/ic_wait_enc.sv
module ic_wait_enc #(
   parameter int N  = 5,
   parameter int WW = 3
) (
   input  logic [N-1:0]  cv_i,
   output logic [WW-1:0] wait_o
);

   logic [WW-1:0] chain [0:N];

   assign chain[N] = WW'(N);

   for (genvar g = N - 1; g >= 0; g--) begin : g_stage
      assign chain[g] = cv_i[g] ? chain[g+1] : WW'(g);
   end

   assign wait_o = chain[0];

endmodule

// File: rtl/init_ctrl.sv
module init_ctrl
   import init_ctrl_pkg::*;
#(
   parameter int            N           = 5,
   parameter logic [N-1:0]  FORBID_MASK = 5'b10010,
   parameter bit            PEND_EN     = 1'b1,
   localparam int           LW          = lat_width(N),
   localparam int           WW          = wait_width(N)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req_i,
   input  logic          greedy_i,
   output logic          grant_o,
   output logic [LW-1:0] lat_o,
   output logic [N-1:0]  cv_o,
   output logic [WW-1:0] wait_o
);

   if (N < 1) begin : g_bad_n
      $error("init_ctrl: N must be at least 1");
   end
   if (FORBID_MASK[N-1] != 1'b1) begin : g_bad_mask
      $error("init_ctrl: top mask bit must be set (N is the largest forbidden latency)");
   end

   logic pend_q;
   logic eff_req;
   logic grant;
   logic [N-1:0] cv;

   assign eff_req = req_i | (pend_q & greedy_i);
   assign grant   = ~rst & eff_req & ~cv[0];

   if (PEND_EN) begin : g_pend
      always_ff @(posedge clk) begin
         if (rst) pend_q <= 1'b0;
         else     pend_q <= greedy_i & eff_req & ~grant;
      end
   end else begin : g_nopend
      assign pend_q = 1'b0;
   end

   ic_state #(.N(N), .ICV(FORBID_MASK)) u_state (
      .clk     (clk),
      .rst     (rst),
      .grant_i (grant),
      .cv_o    (cv)
   );

   ic_latcnt #(.N(N), .LW(LW)) u_latcnt (
      .clk     (clk),
      .rst     (rst),
      .grant_i (grant),
      .lat_o   (lat_o)
   );

   ic_wait_enc #(.N(N), .WW(WW)) u_wait (
      .cv_i   (cv),
      .wait_o (wait_o)
   );

   assign grant_o = grant;
   assign cv_o    = cv;

   // R9
   wait_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (wait_o == '0) == !cv_o[0]);

endmodule

// File: tb/init_ctrl_bench.sv
`timescale 1ns/100ps
module init_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       req = 1'b0;
   logic       greedy = 1'b0;
   logic       grant;
   logic [2:0] lat;
   logic [4:0] cv;
   logic [2:0] wt;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   init_ctrl u_init_ctrl (
      .clk(clk), .rst(rst), .req_i(req), .greedy_i(greedy),
      .grant_o(grant), .lat_o(lat), .cv_o(cv), .wait_o(wt)
   );

   task automatic chk(input string tag, input int got, input int exp);
      tests++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // one cycle: drive at negedge, settle, outputs then describe this cycle
   task automatic cyc(input logic r, input logic g);
      @(negedge clk);
      req = r; greedy = g;
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; req = 1'b1; greedy = 1'b1;
      #1;
      chk("R1 grant low in reset", int'(grant), 0);
      @(negedge clk);
      req = 1'b0; greedy = 1'b0;
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      cyc(0, 0);
      chk("R1 state cleared", int'(cv), 0);
      chk("R9 wait from empty", int'(wt), 0);
   endtask

   task automatic t_icv();
      do_reset();
      cyc(1, 0);
      chk("R6 grant from empty", int'(grant), 1);
      chk("R8 first grant latency", int'(lat), 0);
      cyc(0, 0);
      chk("R2 loaded vector", int'(cv), 5'b10010);
   endtask

   task automatic t_hold();
      int exp_lat [0:14];
      int k;
      do_reset();
      for (int i = 0; i < 15; i++) exp_lat[i] = -1;
      exp_lat[0] = 0; exp_lat[1] = 1; exp_lat[4] = 3; exp_lat[7] = 3;
      exp_lat[8] = 1; exp_lat[11] = 3; exp_lat[14] = 3;
      for (k = 0; k < 15; k++) begin
         cyc(1, 0);
         chk($sformatf("R7 grant at offset %0d", k), int'(grant),
             (exp_lat[k] >= 0) ? 1 : 0);
         if (exp_lat[k] >= 0)
            chk($sformatf("R8 latency at offset %0d", k), int'(lat), exp_lat[k]);
         if (k == 2) chk("R7 state after lat 1", int'(cv), 5'b11011);
         if (k == 5) chk("R7 state after lat 3", int'(cv), 5'b10011);
         if (k == 8) chk("R7 state back to start", int'(cv), 5'b10010);
      end
   endtask

   task automatic t_forbidden();
      do_reset();
      cyc(1, 0);                                   // k0
      cyc(0, 0);                                   // k1
      cyc(1, 0);                                   // k2
      chk("R5 latency 2 refused", int'(grant), 0);
      chk("R3 refused with bit0 set", int'(cv), 5'b01001);
      cyc(0, 0);                                   // k3
      chk("R4 shift after drop", int'(cv), 5'b00100);
      cyc(0, 0);                                   // k4
      cyc(1, 0);                                   // k5
      chk("R5 latency 5 refused", int'(grant), 0);
      cyc(1, 0);                                   // k6
      chk("R5 latency 6 accepted", int'(grant), 1);
      chk("R8 latency six", int'(lat), 6);
      for (int j = 7; j < 15; j++) cyc(0, 0);
      chk("R6 stays empty", int'(cv), 0);
      cyc(1, 0);                                   // k15, latency 9
      chk("R6 grant after long wait", int'(grant), 1);
      chk("R8 saturated latency", int'(lat), 6);
   endtask

   task automatic t_wait();
      do_reset();
      cyc(1, 0);
      cyc(1, 0);
      cyc(0, 0);
      chk("R9 wait at 11011", int'(wt), 2);
      cyc(0, 0);
      chk("R9 wait at 01101", int'(wt), 1);
      cyc(0, 0);
      chk("R9 wait at 00110", int'(wt), 0);
   endtask

   task automatic t_pending();
      // greedy: blocked request is remembered
      do_reset();
      cyc(1, 1); cyc(0, 1); cyc(1, 1);
      chk("R10 greedy blocked", int'(grant), 0);
      cyc(0, 1);
      chk("R10 pending granted", int'(grant), 1);
      chk("R10 pending latency", int'(lat), 3);
      // plain: blocked request is dropped
      do_reset();
      cyc(1, 0); cyc(0, 0); cyc(1, 0); cyc(0, 0);
      chk("R10 dropped request", int'(grant), 0);
      cyc(0, 0);
      chk("R10 state untouched by drop", int'(cv), 5'b00010);
      // greedy removed: pending discarded
      do_reset();
      cyc(1, 1); cyc(0, 1); cyc(1, 1); cyc(0, 0);
      chk("R10 pending masked", int'(grant), 0);
      cyc(0, 1);
      chk("R10 pending discarded", int'(grant), 0);
   endtask

   initial begin
      t_reset();
      t_icv();
      t_hold();
      t_forbidden();
      t_wait();
      t_pending();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #100000;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule